// File: doc/BRIEF.md
# Line Request Tracker

This block sits beside a shared snooping bus and tracks the cache-line requests that are still pending on it. It keeps a small table of those requests. Each entry holds a line address, a shared or exclusive mode flag and the ID of the requester that opened it. When a new request arrives, all valid entries are compared with it in parallel, in one cycle. The block then returns a registered verdict: fold the request into a pending shared read, refuse it, hold it behind the pending entry for the same line, park it in the overflow queue because the table is full, or pass it on to high-priority arbitration.

When a cacheable request is passed on to arbitration, the block also opens a table entry for it at the lowest free slot and reports that slot. A retire port closes an entry by index once the bus transaction it stands for has completed. The arbiter, memory timing and data movement sit outside this block. They act on the verdict code and the reported index.

Top module: `line_request_tracker`

## Requirements
- R1: After reset, rsp_valid is 0 and the table is empty, so the first GET with no other traffic receives ARBITRATE with index 0.
- R2: A request sampled at clock edge N yields a response on rsp_valid, rsp_code, rsp_idx and rsp_owner after edge N+1 only. rsp_valid is high for exactly that one cycle and is low in every cycle that follows an edge without a request.
- R3: If a GET (req_cmd=0) matches a valid shared entry, the result is MERGE (code 0), with rsp_idx set to that entry and rsp_owner set to its requester ID. This applies even when the table is full.
- R4: If an UPGRADE (req_cmd=2) matches a valid exclusive entry, the result is NAK (code 1), with the entry's index and requester ID.
- R5: Any other line match gives DELAY (code 2), with the entry's index and requester ID. This covers GETX (req_cmd=1) against any entry, GET against an exclusive entry, UPGRADE against a shared entry, and OTHER (req_cmd=3) against any entry.
- R6: A GET or GETX that matches no entry while all entries are valid gives OVERFLOW (code 3), with rsp_idx 0 and rsp_owner 0. The table is left unchanged.
- R7: A GET, GETX or UPGRADE that matches no entry while a free slot exists gives ARBITRATE (code 4). It allocates the lowest free index and reports it. The new entry is shared for GET and exclusive for GETX and UPGRADE.
- R8: An OTHER request with no match never allocates. An UPGRADE with no match on a full table does not allocate either. Both give ARBITRATE with rsp_idx 0 and rsp_owner 0.
- R9: A retire pulse with index k clears entry k. A later request for that entry's line then matches nothing, and the entry is reused by the next allocation.
- R10: A request in the same cycle as a retire is judged against the table as it stood before that retire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_cmd | input | 2 | 0 GET, 1 GETX, 2 UPGRADE, 3 OTHER |
| req_line | input | ADDR_W | Line address of the request |
| req_src | input | ID_W | Requester ID |
| ret_valid | input | 1 | Retire an entry |
| ret_idx | input | IDX_W | Index of the entry to retire |
| rsp_valid | output | 1 | Verdict present |
| rsp_code | output | 3 | 0 MERGE, 1 NAK, 2 DELAY, 3 OVERFLOW, 4 ARBITRATE |
| rsp_idx | output | IDX_W | Matched or allocated entry, otherwise 0 |
| rsp_owner | output | ID_W | Requester ID of the matched entry, otherwise 0 |

## Verification
The hardest states to reach are the ones that only appear with a full table. These are the overflow verdict, the non-allocating upgrade, and a merge that still succeeds while no slot is free. The stimulus reaches them by first opening entries with distinct lines until all eight slots are valid, and then sending misses and hits against that full table. A retire is also issued in the same cycle as a request to the retired line, which shows that the verdict uses the table as it was before the retire.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [1:0] {
    CMD_GET  = 2'd0,
    CMD_GETX = 2'd1,
    CMD_UPG  = 2'd2,
    CMD_OTH  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RES_MERGE = 3'd0,
    RES_NAK   = 3'd1,
    RES_DELAY = 3'd2,
    RES_OVF   = 3'd3,
    RES_ARB   = 3'd4
  } res_e;
endpackage

// File: rtl/lrt_first_set.sv
module lrt_first_set #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lrt_match.sv
module lrt_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ADDR_W-1:0]  ent_line [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = ent_valid[g] && (ent_line[g] == key);
  end
endmodule

// File: rtl/lrt_decide.sv
module lrt_decide
  import lrt_pkg::*;
(
  input  cmd_e cmd,
  input  logic any_hit,
  input  logic hit_excl,
  input  logic tbl_full,
  output res_e verdict,
  output logic alloc
);
  logic cacheable;
  assign cacheable = (cmd != CMD_OTH);

  always_comb begin
    alloc = 1'b0;
    if (any_hit) begin
      if (!hit_excl && cmd == CMD_GET)      verdict = RES_MERGE;
      else if (hit_excl && cmd == CMD_UPG)  verdict = RES_NAK;
      else                                  verdict = RES_DELAY;
    end else if (tbl_full && (cmd == CMD_GET || cmd == CMD_GETX)) begin
      verdict = RES_OVF;
    end else begin
      verdict = RES_ARB;
      alloc   = cacheable && !tbl_full;
    end
  end
endmodule

// File: rtl/line_request_tracker.sv
module line_request_tracker
  import lrt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int ID_W    = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_src,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ID_W-1:0]   rsp_owner
);
  logic [ENTRIES-1:0] tbl_valid;
  logic [ENTRIES-1:0] tbl_excl;
  logic [ADDR_W-1:0]  tbl_line [ENTRIES];
  logic [ID_W-1:0]    tbl_src  [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit, any_free;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic               tbl_full;
  res_e               verdict;
  logic               alloc;
  logic               alloc_en;
  cmd_e               cmd;

  assign cmd      = cmd_e'(req_cmd);
  assign tbl_full = &tbl_valid;

  lrt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .ent_valid (tbl_valid),
    .ent_line  (tbl_line),
    .key       (req_line),
    .hit       (hit_vec)
  );

  lrt_first_set #(.N(ENTRIES)) u_hit_pick (
    .vec   (hit_vec),
    .found (any_hit),
    .idx   (hit_idx)
  );

  lrt_first_set #(.N(ENTRIES)) u_free_pick (
    .vec   (~tbl_valid),
    .found (any_free),
    .idx   (free_idx)
  );

  lrt_decide u_decide (
    .cmd      (cmd),
    .any_hit  (any_hit),
    .hit_excl (tbl_excl[hit_idx]),
    .tbl_full (tbl_full),
    .verdict  (verdict),
    .alloc    (alloc)
  );

  assign alloc_en = req_valid && alloc && any_free;

  // table state: retire first, allocation (always to a free slot) after
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_valid <= '0;
      tbl_excl  <= '0;
    end else begin
      if (ret_valid) tbl_valid[ret_idx] <= 1'b0;
      if (alloc_en) begin
        tbl_valid[free_idx] <= 1'b1;
        tbl_excl[free_idx]  <= (cmd != CMD_GET);
      end
    end
  end

  // payload storage without reset
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tbl_line[free_idx] <= req_line;
      tbl_src[free_idx]  <= req_src;
    end
  end

  // registered verdict
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_idx   <= '0;
      rsp_owner <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= verdict;
        if (any_hit) begin
          rsp_idx   <= hit_idx;
          rsp_owner <= tbl_src[hit_idx];
        end else begin
          rsp_idx   <= alloc_en ? free_idx : '0;
          rsp_owner <= '0;
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_MERGE_ONLY_GET: assert property (@(posedge clk) disable iff (rst)
    req_valid && cmd != CMD_GET |=> rsp_code != RES_MERGE); // R3
  AST_NAK_ONLY_UPG: assert property (@(posedge clk) disable iff (rst)
    req_valid && cmd != CMD_UPG |=> rsp_code != RES_NAK); // R4
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    req_valid && !tbl_full |=> rsp_code != RES_OVF); // R6
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (rst)
    alloc_en && !ret_valid |=> $countones(tbl_valid) == $past($countones(tbl_valid)) + 1); // R7
  AST_OVF_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
    req_valid && verdict == RES_OVF && !ret_valid |=> $stable(tbl_valid)); // R6
endmodule

// File: tb/test_line_request_tracker.sv
`timescale 1ns/1ps
module test_line_request_tracker;
  localparam int ADDR_W = 26;
  localparam int ID_W   = 4;
  localparam int IDX_W  = 3;

  localparam logic [1:0] GET = 2'd0, GETX = 2'd1, UPG = 2'd2, OTH = 2'd3;
  localparam logic [2:0] MRG = 3'd0, NAK = 3'd1, DLY = 3'd2, OVF = 3'd3, ARB = 3'd4;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [1:0]        req_cmd;
  logic [ADDR_W-1:0] req_line;
  logic [ID_W-1:0]   req_src;
  logic              ret_valid;
  logic [IDX_W-1:0]  ret_idx;
  logic              rsp_valid;
  logic [2:0]        rsp_code;
  logic [IDX_W-1:0]  rsp_idx;
  logic [ID_W-1:0]   rsp_owner;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  line_request_tracker i_line_request_tracker (
    .clk, .rst, .req_valid, .req_cmd, .req_line, .req_src,
    .ret_valid, .ret_idx, .rsp_valid, .rsp_code, .rsp_idx, .rsp_owner
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request (optionally with a retire), check the verdict one edge later
  task automatic send(string req, logic [1:0] c, logic [ADDR_W-1:0] ln, logic [ID_W-1:0] s,
                      logic [2:0] ecode, logic [IDX_W-1:0] eidx, logic [ID_W-1:0] eown,
                      logic rv = 1'b0, logic [IDX_W-1:0] ri = '0);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_line = ln; req_src = s;
    ret_valid = rv; ret_idx = ri;
    @(negedge clk);
    req_valid = 1'b0; ret_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " code"},  32'(rsp_code),  32'(ecode));
    check({req, " idx"},   32'(rsp_idx),   32'(eidx));
    check({req, " owner"}, 32'(rsp_owner), 32'(eown));
  endtask

  task automatic retire(logic [IDX_W-1:0] i);
    @(negedge clk);
    ret_valid = 1'b1; ret_idx = i;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; ret_valid = 1'b0;
    req_cmd = GET; req_line = '0; req_src = '0; ret_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    send("R1 first GET", GET, 26'h100, 4'd1, ARB, 3'd0, 4'd0);
    @(negedge clk);
    check("R2 pulse ends", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_merge_nak_delay;
    send("R3 GET merge",      GET,  26'h100, 4'd2, MRG, 3'd0, 4'd1);
    send("R7 GETX alloc",     GETX, 26'h200, 4'd3, ARB, 3'd1, 4'd0);
    send("R4 UPG vs excl",    UPG,  26'h200, 4'd4, NAK, 3'd1, 4'd3);
    send("R5 UPG vs shared",  UPG,  26'h100, 4'd5, DLY, 3'd0, 4'd1);
    send("R5 GETX vs shared", GETX, 26'h100, 4'd5, DLY, 3'd0, 4'd1);
    send("R5 GET vs excl",    GET,  26'h200, 4'd5, DLY, 3'd1, 4'd3);
    send("R5 OTH vs entry",   OTH,  26'h100, 4'd5, DLY, 3'd0, 4'd1);
  endtask

  task automatic t_modes_other;
    send("R7 UPG alloc",      UPG,  26'h300, 4'd6, ARB, 3'd2, 4'd0);
    send("R7 UPG entry excl", GET,  26'h300, 4'd7, DLY, 3'd2, 4'd6);
    send("R8 OTH no alloc",   OTH,  26'h400, 4'd8, ARB, 3'd0, 4'd0);
    send("R8 OTH left free",  GET,  26'h400, 4'd9, ARB, 3'd3, 4'd0);
  endtask

  task automatic t_full;
    for (int i = 4; i < 8; i++)
      send("R7 fill", GET, ADDR_W'(26'h500 + i), 4'(i), ARB, IDX_W'(i), 4'd0);
    send("R6 GET overflow",   GET,  26'h900, 4'd1, OVF, 3'd0, 4'd0);
    send("R6 GETX overflow",  GETX, 26'h901, 4'd1, OVF, 3'd0, 4'd0);
    send("R6 table kept",     GET,  26'h900, 4'd1, OVF, 3'd0, 4'd0);
    send("R8 UPG full",       UPG,  26'h902, 4'd1, ARB, 3'd0, 4'd0);
    send("R8 OTH full",       OTH,  26'h903, 4'd1, ARB, 3'd0, 4'd0);
    send("R3 merge when full", GET, 26'h100, 4'd2, MRG, 3'd0, 4'd1);
  endtask

  task automatic t_retire;
    retire(3'd1);
    send("R9 reuse idx1",     GETX, 26'h200, 4'd4, ARB, 3'd1, 4'd0);
    retire(3'd5);
    send("R9 reuse idx5",     GET,  26'h505, 4'd2, ARB, 3'd5, 4'd0);
    send("R10 retire same cycle", GET, 26'h300, 4'd7, DLY, 3'd2, 4'd6, 1'b1, 3'd2);
    send("R9 after retire",   GET,  26'h300, 4'd7, ARB, 3'd2, 4'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_merge_nak_delay();
        t_modes_other();
        t_full();
        t_retire();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule